// File: doc/BRIEF.md
# Asynchronous Byte-Wide Static Memory Controller

This block is a clocked master for an asynchronous static memory of 2048 bytes. A host issues single-byte read or write requests on a valid/ready port. The controller turns each request into a strobe sequence on the active-low chip-select, write-strobe and output-enable lines, with an 11-bit address and a split 8-bit data bus: `mem_dq_out` and `mem_dq_oe` go to a pad tristate, and `mem_dq_in` comes back from it. Every phase lasts a whole number of clocks. Each phase length is the ceiling of the relevant memory time divided by the `CLK_NS` clock-period parameter, with a floor of one clock. The memory times come from a speed-grade parameter (`GRADE_NS`, one of 100, 120, 150 or 200).

The request port accepts one transfer when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while the controller is idle, so the host is back-pressured for the whole memory cycle and until the response has been taken. The response port holds `rsp_valid`, `rsp_rdata` and `rsp_err` unchanged until `rsp_ready` is seen high at a clock edge. A write-protect input refuses new requests. A refused request is answered with an error flag and moves no strobe.

Top module: `sram_async_ctrl`

## Requirements
- R1: A read drives chip-select and output-enable low with write-strobe high for RD_CYC = max(ceil(t_acc/CLK_NS), ceil(t_oe/CLK_NS)) clocks. The byte on `mem_dq_in` is captured at the clock edge that ends this window, so 5 clocks at grade 100 with CLK_NS = 20.
- R2: A write holds chip-select and write-strobe low together for exactly WP_CYC clocks, which is 4 at grade 100 with CLK_NS = 20. `mem_addr` does not change while chip-select is low.
- R3: Output-enable is high whenever write-strobe is low. `mem_dq_oe` is never high while output-enable is low.
- R4: Write data is driven on `mem_dq_out` with `mem_dq_oe` high from the first clock of the write window. This gives at least WP_CYC clocks of setup before the window closes.
- R5: After a write window, all strobes are high for REC_CYC clocks while the data is still driven. This serves as the hold and recovery time, and WP_CYC + REC_CYC covers the write cycle time. At grade 100 with CLK_NS = 20, REC_CYC is 1.
- R6: After a read window, chip-select stays high for at least OD_CYC = ceil(35/CLK_NS) clocks before any new strobe or bus drive. This is 2 at CLK_NS = 20.
- R7: `GRADE_NS` selects the memory timing set for 100, 120, 150 or 200 ns parts. The read and write cycles are never shorter than the grade's cycle time.
- R8: A request accepted while `wp_in` is high produces a response with `rsp_err` = 1. No strobe falls for it, and the memory byte it names keeps its value.
- R9: `req_ready` is high only when no access or response is pending. While `rsp_valid` is high and `rsp_ready` is low, the response fields hold steady.
- R10: Each phase length is ceil(time/CLK_NS) with a floor of one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this edge when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 8 | Read byte |
| rsp_err | output | 1 | Request refused by write protect |
| wp_in | input | 1 | Write protect: refuse new requests |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 11 | Memory address |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Enable for the data pad driver |
| mem_dq_in | input | 8 | Data from memory |

## Verification
The assertions check on every cycle that output-enable is high during write strobes, that the bus is never driven while output-enable is low, that the address is frozen while chip-select is low, that every write pulse meets its minimum length, that a protected request raises no strobe, and that a stalled response holds steady. Only the bench scenarios can show that the right byte comes back. This is shown by a full write-then-read sweep against a memory model that returns corrupt data before the access time. The scenarios also show that the window and gap lengths match the computed counts exactly, and that a refused write leaves its byte unchanged.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RREC, ST_WR, ST_WREC, ST_RSP
  } sram_st_e;

  function automatic int ceil_clk(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int t_oe_ns(input int g);
    case (g)
      100: return 50;
      120: return 60;
      150: return 70;
      default: return 100;
    endcase
  endfunction

  function automatic int t_wp_ns(input int g);
    case (g)
      100: return 75;
      120: return 90;
      150: return 100;
      default: return 150;
    endcase
  endfunction

  function automatic int t_ds_ns(input int g);
    case (g)
      100: return 40;
      120: return 50;
      150: return 60;
      default: return 50;
    endcase
  endfunction

  function automatic int t_cyc_ns(input int g);
    case (g)
      100, 120, 150: return g;
      default: return 200;
    endcase
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RD_CYC  = 5,
  parameter int OD_CYC  = 2,
  parameter int WP_CYC  = 4,
  parameter int REC_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             wp_in,
  input  logic             rsp_ready,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             idle,
  output logic             rsp_pend,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);
  sram_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (req_valid) st_d = wp_in ? ST_RSP : (req_write ? ST_WR : ST_RD);
      ST_RD:   if (tmr_done) st_d = ST_RREC;
      ST_RREC: if (tmr_done) st_d = ST_RSP;
      ST_WR:   if (tmr_done) st_d = ST_WREC;
      ST_WREC: if (tmr_done) st_d = ST_RSP;
      ST_RSP:  if (rsp_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    tmr_load = (st_d != st_q);
    case (st_d)
      ST_RD:   tmr_val = CNT_W'(RD_CYC - 1);
      ST_RREC: tmr_val = CNT_W'(OD_CYC - 1);
      ST_WR:   tmr_val = CNT_W'(WP_CYC - 1);
      ST_WREC: tmr_val = CNT_W'(REC_CYC - 1);
      default: tmr_val = '0;
    endcase
  end

  assign idle     = (st_q == ST_IDLE);
  assign accept   = idle && req_valid;
  assign capture  = (st_q == ST_RD) && tmr_done;
  assign rsp_pend = (st_q == ST_RSP);
  assign ce_n     = !((st_q == ST_RD) || (st_q == ST_WR));
  assign we_n     = (st_q != ST_WR);
  assign oe_n     = (st_q != ST_RD);
  assign dq_oe    = (st_q == ST_WR) || (st_q == ST_WREC);

  assert_oe_high_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (oe_n && !ce_n));
  assert_no_drive_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);
  assert_data_from_window_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> dq_oe);
endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic          wp_in,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        err_q   <= wp_in;
      end
      if (capture) rdata_q <= mem_dq_in;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_NS   = 20,
  parameter int GRADE_NS = 100,
  parameter int AW       = 11,
  parameter int DW       = 8,
  parameter int T_OD_NS  = 35,
  parameter int T_WR_NS  = 10,
  parameter int T_DH_NS  = 10,
  parameter int CNT_W    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  input  logic          wp_in,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int CYC_NS  = t_cyc_ns(GRADE_NS);
  localparam int RD_CYC  = max2(ceil_clk(CYC_NS, CLK_NS), ceil_clk(t_oe_ns(GRADE_NS), CLK_NS));
  localparam int OD_CYC  = ceil_clk(T_OD_NS, CLK_NS);
  localparam int REC_CYC = max2(ceil_clk(T_WR_NS, CLK_NS), ceil_clk(T_DH_NS, CLK_NS));
  localparam int WP_MIN  = max2(ceil_clk(t_wp_ns(GRADE_NS), CLK_NS), ceil_clk(t_ds_ns(GRADE_NS), CLK_NS));
  localparam int WP_CYC  = max2(WP_MIN, ceil_clk(CYC_NS, CLK_NS) - REC_CYC);

  logic             tmr_load, tmr_done, accept, capture, idle, rsp_pend;
  logic [CNT_W-1:0] tmr_val;

  sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  sram_ctrl_fsm #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .OD_CYC(OD_CYC), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .wp_in(wp_in), .rsp_ready(rsp_ready), .tmr_done(tmr_done), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .accept(accept), .capture(capture), .idle(idle),
    .rsp_pend(rsp_pend), .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n),
    .dq_oe(mem_dq_oe)
  );

  sram_ctrl_dp #(.AW(AW), .DW(DW)) dp_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture), .wp_in(wp_in),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
    .addr_q(mem_addr), .wdata_q(mem_dq_out), .rdata_q(rsp_rdata), .err_q(rsp_err)
  );

  assign req_ready = idle;
  assign rsp_valid = rsp_pend;

  logic [CNT_W-1:0] we_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        we_run_q <= '0;
    else if (!mem_we_n) we_run_q <= we_run_q + 1'b1;
    else               we_run_q <= '0;
  end

  assert_pulse_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (32'(we_run_q) >= WP_CYC));
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  assert_wp_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && wp_in) |=> (mem_ce_n && rsp_valid && rsp_err));
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
  assert_ready_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !rsp_valid));
  initial begin
    assert_phase_floor_R10: assert (RD_CYC >= 1 && OD_CYC >= 1 && WP_CYC >= 1 && REC_CYC >= 1 && GRADE_NS > 0);
  end
endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;
  localparam int CLK_NS  = 20;
  localparam int RD_EXP  = (100 + CLK_NS - 1) / CLK_NS;  // R1: max(ceil(100/20), ceil(50/20))
  localparam int WP_EXP  = 4;                            // R2: max(ceil(75/20), ceil(40/20), 5-1)
  localparam int REC_EXP = 1;                            // R5: ceil(10/20)
  localparam int OD_EXP  = 2;                            // R6: ceil(35/20)

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1, wp_in = 0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, ce_n, we_n, oe_n, dq_oe;
  logic [7:0] rsp_rdata, dq_out, dq_in;
  logic [10:0] maddr;

  int total = 0, bad = 0, cycles = 0;
  logic [7:0] mem [2048];

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl #(.CLK_NS(CLK_NS), .GRADE_NS(100)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .wp_in(wp_in), .mem_ce_n(ce_n), .mem_we_n(we_n),
    .mem_oe_n(oe_n), .mem_addr(maddr), .mem_dq_out(dq_out), .mem_dq_oe(dq_oe),
    .mem_dq_in(dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model and strobe monitor, sampled mid-cycle
  int rcnt = 0, wcnt = 0, gap = 100, ce_falls = 0, since_rd = 100;
  bit last_rd = 0;
  logic [10:0] win_addr;
  logic [7:0]  win_data;
  assign dq_in = (rcnt >= RD_EXP) ? mem[maddr] : ~mem[maddr];

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ce_n && gap > 0) begin  // chip select falls
        ce_falls++;
        chk(gap >= (last_rd ? OD_EXP : REC_EXP), "R5/R6 deselect gap", gap, last_rd ? OD_EXP : REC_EXP);
        win_addr = maddr;
      end
      if (!ce_n) begin
        gap = 0;
        if (maddr !== win_addr) chk(0, "R2 address stable", maddr, win_addr);
      end else gap++;
      if (!we_n) begin
        if (!oe_n || ce_n) chk(0, "R3 oe high in write", oe_n, 1);
        if (!dq_oe) chk(0, "R4 data driven in window", dq_oe, 1);
        wcnt++;
        win_data = dq_out;
      end else if (wcnt > 0) begin
        chk(wcnt == WP_EXP, "R2 write pulse", wcnt, WP_EXP);
        chk(dq_oe == 1'b1, "R5 data hold after window", dq_oe, 1);
        mem[win_addr] = win_data;
        wcnt = 0;
        last_rd = 0;
      end
      if (dq_oe && !oe_n) chk(0, "R3 drive during read", 1, 0);
      if (dq_oe && since_rd < OD_EXP) chk(0, "R6 drive after read", since_rd, OD_EXP);
      if (!ce_n && !oe_n) begin
        rcnt++;
        since_rd = 0;
      end else begin
        if (rcnt > 0) begin
          chk(rcnt == RD_EXP, "R1 read window", rcnt, RD_EXP);
          last_rd = 1;
        end
        rcnt = 0;
        if (since_rd < 100) since_rd++;
      end
    end
  end

  task automatic xfer(input bit wr, input logic [10:0] a, input logic [7:0] d,
                      output logic [7:0] rd, output logic err);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata; err = rsp_err;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 37 + 11 + k * 91) & 255);
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(0, "watchdog", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] rd, hold_d;
    logic err;
    int f0;
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n && !dq_oe, "R9 reset strobes idle", {ce_n, we_n, oe_n, dq_oe}, 14);
    chk(!rsp_valid, "R9 reset no response", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R9 ready after reset", req_ready, 1);

    // R2 R4 R5 full write sweep, then R1 full read sweep
    for (int a = 0; a < 2048; a++) xfer(1, 11'(a), pat(a, 0), rd, err);
    for (int a = 0; a < 2048; a++) begin
      xfer(0, 11'(a), 8'h00, rd, err);
      chk(rd == pat(a, 0) && !err, "R1 read data", rd, pat(a, 0));
    end

    // R7 overwrite subset, alternate read/write back to back
    for (int a = 0; a < 2048; a += 61) begin
      xfer(1, 11'(a), pat(a, 1), rd, err);
      xfer(0, 11'(a), 8'h00, rd, err);
      chk(rd == pat(a, 1), "R7 rewrite then read", rd, pat(a, 1));
    end

    // R8 write protect: error, no strobe, byte unchanged
    f0 = ce_falls;
    wp_in = 1;
    xfer(1, 11'd5, 8'hEE, rd, err);
    chk(err == 1'b1, "R8 error flag", err, 1);
    xfer(0, 11'd6, 8'h00, rd, err);
    chk(err == 1'b1, "R8 read refused", err, 1);
    chk(ce_falls == f0, "R8 no strobe", ce_falls - f0, 0);
    wp_in = 0;
    xfer(0, 11'd5, 8'h00, rd, err);
    chk(rd == pat(5, 0) && !err, "R8 byte kept", rd, pat(5, 0));

    // R9 response back-pressure
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 11'd7;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    hold_d = rsp_rdata;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == hold_d && !req_ready, "R9 response held", rsp_rdata, hold_d);
    end
    chk(hold_d == pat(7, 0), "R9 held data", hold_d, pat(7, 0));
    rsp_ready = 1;
    @(negedge clk);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9 released", rsp_valid, 0);
    // R10 phase floor reflected in minimum windows
    chk(REC_EXP >= 1 && OD_EXP >= 1, "R10 floor", REC_EXP, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule